// File: doc/BRIEF.md
# Scheduled Multi-Domain Reset Release

This block sits beside a reset sequencer that runs on a wakeup clock and publishes a count value. The count restarts from zero on every reset event and then climbs until it saturates. From that count the block derives one synchronous reset for each application clock domain. Each domain has its own release slot, given as a count value. Domains therefore leave reset in a fixed, configured order rather than in whatever order their synchronizers happen to settle.

For each domain, a reset request is computed and registered in the wakeup domain. The request is then carried into the domain's own clock through a chain of three preset flip-flops. The block also produces, in the wakeup domain, a registered clock-enable for each domain and a registered asynchronous-reset strobe. These are derived from count ranges, so that an asynchronous reset can be applied while that domain's clock is stopped. An active-low power-on input presets every flop to its reset state.

Top module: `rrs_release_sched`

## Requirements
- R1: While `por_n` is low, every `dom_rst` bit is 1, every `dom_clk_en` bit is 1 and every `dom_arst` bit is 0, whatever `seq_count` holds.
- R2: The wakeup-domain request for domain i is 1 after any wakeup edge that sampled `seq_count` below `REL_AT[i]`, and 0 after an edge that sampled it at or above `REL_AT[i]`. If the count steps by one from zero, domain i's reset therefore lasts at least `REL_AT[i]` wakeup cycles.
- R3: A change of domain i's request appears on `dom_rst[i]` at the third rising edge of `dom_clk[i]` after the wakeup edge that registered the change, and not at the second.
- R4: With `REL_AT` strictly increasing in the domain index, domain i is released before domain i+1, and `dom_rst[i+1]` is still 1 when `dom_rst[i]` falls.
- R5: A count of zero sets every request again on the next wakeup edge. Every domain that had been released re-enters reset through its synchronizer, including after a partial sequence.
- R6: `dom_clk_en[i]` is 0 after a wakeup edge that sampled the count inside the inclusive range `GATE_LO[i]`..`GATE_HI[i]`, and 1 otherwise.
- R7: `dom_arst[i]` is 1 after a wakeup edge that sampled the count inside the inclusive range `ARST_LO[i]`..`ARST_HI[i]`, and 0 otherwise. Because that range lies within the gating range, `dom_arst[i]` is never 1 while `dom_clk_en[i]` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wk_clk | input | 1 | Wakeup clock that the count is synchronous to |
| por_n | input | 1 | Asynchronous active-low power-on preset |
| seq_count | input | CW | Sequencer count value |
| dom_clk | input | N | One application clock per domain |
| dom_rst | output | N | Synchronous active-high reset, bit i in `dom_clk[i]` |
| dom_clk_en | output | N | Registered clock-enable per domain, wakeup domain |
| dom_arst | output | N | Registered asynchronous-reset strobe per domain, wakeup domain |

## Verification
The bench builds the block with three domains, a 6-bit count, release slots 8, 16 and 24, and overlapping gating windows whose asynchronous-reset ranges sit one count inside each edge. Each domain clock has a different period, and every domain edge is placed at an odd nanosecond while wakeup edges fall on even ones. This lets the bench count domain edges after a release without races. It also shows that the release order comes from the slots and not from the clock rates. Because the windows overlap, the sweep can check the gating and strobe boundaries of all three domains in a single count pass.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

  // Inclusive range test shared by the gating and strobe windows.
  function automatic logic in_span(input int unsigned v,
                                   input int unsigned lo,
                                   input int unsigned hi);
    return (v >= lo) && (v <= hi);
  endfunction

endpackage

// File: rtl/rrs_slot.sv
module rrs_slot
  import rrs_pkg::*;
#(
  parameter int unsigned CW  = 6,
  parameter int unsigned REL = 8,
  parameter int unsigned GLO = 2,
  parameter int unsigned GHI = 6,
  parameter int unsigned ALO = 3,
  parameter int unsigned AHI = 5
) (
  input  logic          wk_clk,
  input  logic          por_n,
  input  logic [CW-1:0] cnt,
  output logic          req,
  output logic          clk_en,
  output logic          arst
);

  logic [31:0] cnt_w;
  assign cnt_w = 32'(cnt);

  always_ff @(posedge wk_clk or negedge por_n) begin
    if (!por_n) begin
      req    <= 1'b1;
      clk_en <= 1'b1;
      arst   <= 1'b0;
    end else begin
      req    <= cnt_w < REL;
      clk_en <= !in_span(cnt_w, GLO, GHI);
      arst   <= in_span(cnt_w, ALO, AHI);
    end
  end

endmodule

// File: rtl/rrs_sync3.sv
module rrs_sync3 #(
  parameter int unsigned DEPTH = 3
) (
  input  logic clk,
  input  logic por_n,
  input  logic d,
  output logic q
);

  logic [DEPTH-1:0] st;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) st <= '1;
    else        st <= {st[DEPTH-2:0], d};
  end

  assign q = st[DEPTH-1];

endmodule

// File: rtl/rrs_release_sched.sv
module rrs_release_sched #(
  parameter int unsigned N           = 3,
  parameter int unsigned CW          = 6,
  parameter int unsigned SYNC_STAGES = 3,
  parameter int unsigned REL_AT  [N] = '{8, 16, 24},
  parameter int unsigned GATE_LO [N] = '{2, 3, 4},
  parameter int unsigned GATE_HI [N] = '{6, 7, 8},
  parameter int unsigned ARST_LO [N] = '{3, 4, 5},
  parameter int unsigned ARST_HI [N] = '{5, 6, 7}
) (
  input  logic          wk_clk,
  input  logic          por_n,
  input  logic [CW-1:0] seq_count,
  input  logic [N-1:0]  dom_clk,
  output logic [N-1:0]  dom_rst,
  output logic [N-1:0]  dom_clk_en,
  output logic [N-1:0]  dom_arst
);

  logic [N-1:0] req;

  for (genvar i = 0; i < N; i++) begin : g_dom
    rrs_slot #(
      .CW (CW),
      .REL(REL_AT[i]),
      .GLO(GATE_LO[i]),
      .GHI(GATE_HI[i]),
      .ALO(ARST_LO[i]),
      .AHI(ARST_HI[i])
    ) u_slot (
      .wk_clk(wk_clk),
      .por_n (por_n),
      .cnt   (seq_count),
      .req   (req[i]),
      .clk_en(dom_clk_en[i]),
      .arst  (dom_arst[i])
    );

    rrs_sync3 #(
      .DEPTH(SYNC_STAGES)
    ) u_sync (
      .clk  (dom_clk[i]),
      .por_n(por_n),
      .d    (req[i]),
      .q    (dom_rst[i])
    );
  end

endmodule

// File: rtl/rrs_release_chk.sv
module rrs_release_chk #(
  parameter int unsigned N          = 3,
  parameter int unsigned CW         = 6,
  parameter int unsigned REL_AT [N] = '{8, 16, 24}
) (
  input logic          wk_clk,
  input logic          por_n,
  input logic [CW-1:0] seq_count,
  input logic [N-1:0]  dom_clk,
  input logic [N-1:0]  req,
  input logic [N-1:0]  dom_rst,
  input logic [N-1:0]  dom_clk_en,
  input logic [N-1:0]  dom_arst
);

  for (genvar i = 0; i < N; i++) begin : g_chk
    a_r7_arst_only_gated: assert property (@(posedge wk_clk) disable iff (!por_n)
      dom_arst[i] |-> !dom_clk_en[i]);

    a_r2_no_early_release: assert property (@(posedge wk_clk) disable iff (!por_n)
      $fell(req[i]) |-> (32'($past(seq_count)) >= REL_AT[i]));

    a_r5_zero_reasserts: assert property (@(posedge wk_clk) disable iff (!por_n)
      (seq_count == '0) |=> req[i]);

    a_r3_sync_depth: assert property (@(posedge dom_clk[i]) disable iff (!por_n)
      $fell(dom_rst[i]) |-> !$past(req[i], 3));

    if (i > 0) begin : g_ord
      a_r4_release_order: assert property (@(posedge wk_clk) disable iff (!por_n)
        !req[i] |-> !req[i-1]);
    end
  end

endmodule

bind rrs_release_sched rrs_release_chk #(
  .N     (N),
  .CW    (CW),
  .REL_AT(REL_AT)
) u_chk (
  .wk_clk    (wk_clk),
  .por_n     (por_n),
  .seq_count (seq_count),
  .dom_clk   (dom_clk),
  .req       (req),
  .dom_rst   (dom_rst),
  .dom_clk_en(dom_clk_en),
  .dom_arst  (dom_arst)
);

// File: tb/sim_rrs_release_sched.sv
`timescale 1ns/1ps
module sim_rrs_release_sched;

  localparam int unsigned N  = 3;
  localparam int unsigned CW = 6;
  localparam int unsigned REL [N] = '{8, 16, 24};
  localparam int unsigned GLO [N] = '{2, 3, 4};
  localparam int unsigned GHI [N] = '{6, 7, 8};
  localparam int unsigned ALO [N] = '{3, 4, 5};
  localparam int unsigned AHI [N] = '{5, 6, 7};
  localparam int unsigned TOP = 40;

  logic          wk_clk = 1'b0;
  logic          por_n  = 1'b0;
  logic [CW-1:0] cnt    = '0;
  logic [N-1:0]  dc     = '0;
  logic [N-1:0]  dom_rst, dom_clk_en, dom_arst;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  rrs_release_sched #(
    .N(N), .CW(CW), .SYNC_STAGES(3),
    .REL_AT(REL), .GATE_LO(GLO), .GATE_HI(GHI), .ARST_LO(ALO), .ARST_HI(AHI)
  ) u0 (
    .wk_clk(wk_clk), .por_n(por_n), .seq_count(cnt), .dom_clk(dc),
    .dom_rst(dom_rst), .dom_clk_en(dom_clk_en), .dom_arst(dom_arst)
  );

  // 125 MHz wakeup clock: rising edges at even ns; domain rising edges at odd ns.
  always #4 wk_clk = ~wk_clk;
  initial begin #1; forever begin dc[0] = 1'b1; #4; dc[0] = 1'b0; #4; end end
  initial begin #5; forever begin dc[1] = 1'b1; #5; dc[1] = 1'b0; #5; end end
  initial begin #3; forever begin dc[2] = 1'b1; #7; dc[2] = 1'b0; #7; end end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit inr(input int unsigned v, input int unsigned lo, input int unsigned hi);
    return (v >= lo) && (v <= hi);
  endfunction

  task automatic wait_dom(input int i, input int n);
    for (int k = 0; k < n; k++) begin
      case (i)
        0: @(posedge dc[0]);
        1: @(posedge dc[1]);
        default: @(posedge dc[2]);
      endcase
    end
    #1;
  endtask

  // Put every domain back in reset with count at zero.
  task automatic restart();
    @(negedge wk_clk); cnt = '0;
    repeat (12) @(negedge wk_clk);
  endtask

  task automatic t_por();
    cnt = 6'd5;
    #30;
    check("R1 dom_rst in por", int'(dom_rst), 7);
    check("R1 clk_en in por", int'(dom_clk_en), 7);
    check("R1 arst in por", int'(dom_arst), 0);
    @(negedge wk_clk); cnt = '0; por_n = 1'b1;
    @(negedge wk_clk);
    check("R1 dom_rst after por", int'(dom_rst), 7);
  endtask

  task automatic t_sweep();
    for (int v = 0; v <= int'(TOP); v++) begin
      @(negedge wk_clk); cnt = CW'(v);
      @(negedge wk_clk);
      for (int i = 0; i < int'(N); i++) begin
        check($sformatf("R6 clk_en[%0d] cnt=%0d", i, v), int'(dom_clk_en[i]),
              inr(v, GLO[i], GHI[i]) ? 0 : 1);
        check($sformatf("R7 arst[%0d] cnt=%0d", i, v), int'(dom_arst[i]),
              inr(v, ALO[i], AHI[i]) ? 1 : 0);
      end
    end
  endtask

  task automatic t_sync_depth();
    restart();
    for (int i = 0; i < int'(N); i++) begin
      @(negedge wk_clk); cnt = CW'(REL[i]);
      @(posedge wk_clk);
      wait_dom(i, 2);
      check($sformatf("R3 dom_rst[%0d] after 2 edges", i), int'(dom_rst[i]), 1);
      wait_dom(i, 1);
      check($sformatf("R3 dom_rst[%0d] after 3 edges", i), int'(dom_rst[i]), 0);
      for (int j = i + 1; j < int'(N); j++)
        check($sformatf("R4 dom_rst[%0d] held while %0d released", j, i), int'(dom_rst[j]), 1);
    end
  endtask

  task automatic t_order();
    int t_rel [N];
    logic [N-1:0] prev;
    restart();
    for (int i = 0; i < int'(N); i++) t_rel[i] = -1;
    prev = dom_rst;
    for (int c = 0; c < 60; c++) begin
      @(negedge wk_clk);
      cnt = (c < int'(TOP)) ? CW'(c) : CW'(TOP);
      for (int i = 0; i < int'(N); i++)
        if (prev[i] && !dom_rst[i] && t_rel[i] < 0) t_rel[i] = c;
      prev = dom_rst;
    end
    for (int i = 0; i < int'(N); i++) begin
      check($sformatf("R2 dom %0d held >= slot", i), int'(t_rel[i] > int'(REL[i])), 1);
      if (i > 0) check($sformatf("R4 order %0d before %0d", i-1, i),
                       int'(t_rel[i-1] < t_rel[i]), 1);
    end
    check("R2 all released", int'(dom_rst), 0);
  endtask

  task automatic t_rezero();
    @(negedge wk_clk); cnt = '0;
    @(posedge wk_clk);
    wait_dom(2, 2);
    check("R3 dom_rst[2] not yet back", int'(dom_rst[2]), 0);
    wait_dom(2, 1);
    check("R5 dom_rst[2] back in reset", int'(dom_rst[2]), 1);
    wait_dom(1, 3);
    check("R5 all back in reset", int'(dom_rst), 7);
    // Partial sequence: release domain 0 only, then restart.
    @(negedge wk_clk); cnt = 6'd12;
    repeat (6) @(negedge wk_clk);
    check("R2 partial: only dom 0 out", int'(dom_rst), 6);
    @(negedge wk_clk); cnt = '0;
    @(posedge wk_clk);
    wait_dom(0, 3);
    check("R5 partial: dom 0 back in reset", int'(dom_rst), 7);
  endtask

  initial begin
    t_por();
    t_sweep();
    t_sync_depth();
    t_order();
    t_rezero();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule